// File: doc/BRIEF.md
# Multi-Bank Open-Row Command Sequencer

This block turns a stream of read and write requests into commands for a synchronous DRAM with several banks. Each request carries a bank, a row and a column address. The block drives one command bus and issues at most one command per rising clock edge. The commands are NOP, ACTIVATE, READ, WRITE and PRECHARGE. A bank whose row is already open gets the column command straight away. A closed bank is activated first. A bank holding some other row is precharged, then activated, then accessed.

Requests enter a small in-order queue through a valid/ready handshake. The column commands leave the queue strictly in arrival order. A younger request for a different bank may still open or close its row early. This lets one bank's row setup overlap the wait in another bank. Each bank runs its own state machine with timing counters:

- **IDLE** moves to **OPENING** on ACTIVATE, or straight to **OPEN** when the row-to-column delay is one cycle.
- **OPENING** moves to **OPEN** when the row-to-column counter runs out.
- **OPEN** moves to **CLOSING** on PRECHARGE, or to **IDLE** when the precharge time is one cycle.
- **CLOSING** moves to **IDLE** when the precharge counter runs out.

A `done` pulse marks the cycle in which a request's column command is on the bus.

Top module: `bank_cmd_sequencer`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The request fields are `req_write` (1 = write), `req_bank`, `req_row` and `req_col`. Up to 4 requests wait in the queue. `req_ready` is low while 4 requests are waiting.
- R2: A request to a bank with no open row produces ACTIVATE (code 3'b001) with the request's row. The column command follows exactly 3 cycles later (tRCD) when nothing else delays it.
- R3: A request whose row equals the row open in its bank produces only its column command, with no ACTIVATE.
- R4: A request to a bank holding a different row produces PRECHARGE (code 3'b100) for that bank. ACTIVATE follows exactly 3 cycles later (tRP), and the column command follows tRCD after that.
- R5: PRECHARGE to a bank is never issued earlier than 6 cycles (tRAS) after that bank's ACTIVATE. When the precharge waits only on tRAS, it is issued exactly 6 cycles after the ACTIVATE.
- R6: The bus carries one command per cycle. It carries NOP (3'b000) on every cycle with no legal command, and always when the queue is empty.
- R7: Column commands are issued in request order. `done` is high for exactly the cycles in which READ (3'b010) or WRITE (3'b011) is on `cmd_op`.
- R8: While an older request waits for its bank, a younger request to another bank whose bank has no older request pending may issue its ACTIVATE or PRECHARGE ahead of the older column command.
- R9: After reset every bank is closed and every counter is clear. `cmd_op` is NOP, `done` is low and `req_ready` is high. A request to any row then needs an ACTIVATE.
- R10: `cmd_bank` names the target bank of every command. `cmd_row` holds the row for ACTIVATE, and `cmd_col` holds the column for READ and WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has a free slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (12) | Target row |
| req_col | input | COL_W (8) | Target column |
| cmd_op | output | 3 | Command code: NOP 0, ACTIVATE 1, READ 2, WRITE 3, PRECHARGE 4 |
| cmd_bank | output | BANK_W (2) | Bank of the command |
| cmd_row | output | ROW_W (12) | Row address, meaningful with ACTIVATE |
| cmd_col | output | COL_W (8) | Column address, meaningful with READ/WRITE |
| done | output | 1 | Request completes in this cycle |

## Verification
The assertions check four rules on every cycle:

- ACTIVATE only reaches an idle bank, and column commands only reach an open bank.
- PRECHARGE respects the activate-to-precharge minimum.
- `done` coincides with column commands.
- An empty queue leaves the bus at NOP, and the queue never underflows.

Only the bench scenarios can show the rest. These are the exact row-to-column and precharge-to-activate spacings, the hit, miss and conflict paths, and in-order completion while other banks open early. They also cover backpressure with a full queue and the loss of all open rows at reset.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Command bus encoding
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    // Per-bank row state
    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPENING,
        BK_OPEN,
        BK_CLOSING
    } bank_st_e;

endpackage

// File: rtl/bcs_req_queue.sv
// In-order request queue; DEPTH must be a power of two.
module bcs_req_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] ent     [DEPTH],
    output logic         ent_vld [DEPTH]
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign full = (cnt == CW'(DEPTH));

    // Entries presented oldest first
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        assign ent[i]     = mem[rd_ptr + PW'(i)];
        assign ent_vld[i] = (cnt > CW'(i));
    end

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/bcs_bank.sv
// One bank: open-row register plus tRCD / tRP / tRAS counters.
module bcs_bank
    import bcs_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_col,
    input  logic [ROW_W-1:0] act_row,
    output bank_st_e         st,
    output logic [ROW_W-1:0] open_row,
    output logic             pre_ok
);
    localparam int TMAX = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                          : ((T_RCD > T_RP) ? T_RCD : T_RP);
    localparam int CW = $clog2(TMAX + 1);

    bank_st_e         st_q, st_d;
    logic [CW-1:0]    wait_q, wait_d;
    logic [CW-1:0]    ras_q, ras_d;
    logic [ROW_W-1:0] row_q, row_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BK_IDLE;
            wait_q <= '0;
            ras_q  <= '0;
            row_q  <= '0;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
            ras_q  <= ras_d;
            row_q  <= row_d;
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        wait_d = wait_q;
        row_d  = row_q;
        ras_d  = (ras_q != '0) ? ras_q - 1'b1 : '0;
        unique case (st_q)
            BK_IDLE: begin
                if (do_act) begin
                    row_d = act_row;
                    ras_d = CW'(T_RAS - 1);
                    if (T_RCD > 1) begin
                        st_d   = BK_OPENING;
                        wait_d = CW'(T_RCD - 1);
                    end else begin
                        st_d = BK_OPEN;
                    end
                end
            end
            BK_OPENING: begin
                if (wait_q <= CW'(1)) begin
                    st_d   = BK_OPEN;
                    wait_d = '0;
                end else begin
                    wait_d = wait_q - 1'b1;
                end
            end
            BK_OPEN: begin
                if (do_pre) begin
                    if (T_RP > 1) begin
                        st_d   = BK_CLOSING;
                        wait_d = CW'(T_RP - 1);
                    end else begin
                        st_d = BK_IDLE;
                    end
                end
            end
            BK_CLOSING: begin
                if (wait_q <= CW'(1)) begin
                    st_d   = BK_IDLE;
                    wait_d = '0;
                end else begin
                    wait_d = wait_q - 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        st       = st_q;
        open_row = row_q;
        pre_ok   = (st_q == BK_OPEN) && (ras_q == '0);
    end

    assert_act_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (st_q == BK_IDLE));
    assert_col_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_col |-> (st_q == BK_OPEN));
    assert_pre_tras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> ((st_q == BK_OPEN) && (ras_q == '0)));
    assert_pre_leaves_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |=> (st_q != BK_OPEN));

endmodule

// File: rtl/bcs_sched.sv
// Picks this cycle's command: head column access first, else earliest
// row preparation among queued requests not shadowed by an older one.
module bcs_sched
    import bcs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              ent_vld  [DEPTH],
    input  logic              ent_we   [DEPTH],
    input  logic [BANK_W-1:0] ent_bank [DEPTH],
    input  logic [ROW_W-1:0]  ent_row  [DEPTH],
    input  logic [COL_W-1:0]  ent_col  [DEPTH],
    input  bank_st_e          bk_st    [NB],
    input  logic [ROW_W-1:0]  bk_row   [NB],
    input  logic              bk_pre_ok[NB],
    output cmd_e              nxt_op,
    output logic [BANK_W-1:0] nxt_bank,
    output logic [ROW_W-1:0]  nxt_row,
    output logic [COL_W-1:0]  nxt_col
);
    logic blocked [DEPTH];
    logic found;

    // An entry is blocked when an older queued entry targets its bank
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j < i && ent_vld[j] && ent_bank[j] == ent_bank[i])
                    blocked[i] = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_op   = CMD_NOP;
        nxt_bank = '0;
        nxt_row  = '0;
        nxt_col  = '0;
        found    = 1'b0;
        if (ent_vld[0] && bk_st[ent_bank[0]] == BK_OPEN
                       && bk_row[ent_bank[0]] == ent_row[0]) begin
            nxt_op   = ent_we[0] ? CMD_WR : CMD_RD;
            nxt_bank = ent_bank[0];
            nxt_row  = ent_row[0];
            nxt_col  = ent_col[0];
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!found && ent_vld[i] && !blocked[i]) begin
                    if (bk_st[ent_bank[i]] == BK_IDLE) begin
                        nxt_op   = CMD_ACT;
                        nxt_bank = ent_bank[i];
                        nxt_row  = ent_row[i];
                        nxt_col  = ent_col[i];
                        found    = 1'b1;
                    end else if (bk_st[ent_bank[i]] == BK_OPEN
                              && bk_row[ent_bank[i]] != ent_row[i]
                              && bk_pre_ok[ent_bank[i]]) begin
                        nxt_op   = CMD_PRE;
                        nxt_bank = ent_bank[i];
                        nxt_row  = ent_row[i];
                        nxt_col  = ent_col[i];
                        found    = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bank_cmd_sequencer.sv
module bank_cmd_sequencer
    import bcs_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int DEPTH  = 4,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              done
);
    localparam int NB = 1 << BANK_W;
    localparam int EW = 1 + BANK_W + ROW_W + COL_W;

    // Queue
    logic          q_full, q_push, q_pop;
    logic [EW-1:0] q_ent [DEPTH];
    logic          q_vld [DEPTH];

    logic              e_we   [DEPTH];
    logic [BANK_W-1:0] e_bank [DEPTH];
    logic [ROW_W-1:0]  e_row  [DEPTH];
    logic [COL_W-1:0]  e_col  [DEPTH];

    // Banks
    bank_st_e         b_st   [NB];
    logic [ROW_W-1:0] b_row  [NB];
    logic             b_preok[NB];
    logic             iss_act[NB], iss_pre[NB], iss_col[NB];

    // Scheduler result and registered bus
    cmd_e              nxt_op;
    logic [BANK_W-1:0] nxt_bank;
    logic [ROW_W-1:0]  nxt_row;
    logic [COL_W-1:0]  nxt_col;
    cmd_e              op_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              done_q;

    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full;
    assign q_pop     = (nxt_op == CMD_RD) || (nxt_op == CMD_WR);

    bcs_req_queue #(.DEPTH(DEPTH), .W(EW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (q_push),
        .din     ({req_write, req_bank, req_row, req_col}),
        .pop     (q_pop),
        .full    (q_full),
        .ent     (q_ent),
        .ent_vld (q_vld)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
        assign {e_we[i], e_bank[i], e_row[i], e_col[i]} = q_ent[i];
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign iss_act[b] = (nxt_op == CMD_ACT) && (nxt_bank == BANK_W'(b));
        assign iss_pre[b] = (nxt_op == CMD_PRE) && (nxt_bank == BANK_W'(b));
        assign iss_col[b] = q_pop && (nxt_bank == BANK_W'(b));

        bcs_bank #(
            .ROW_W (ROW_W),
            .T_RCD (T_RCD),
            .T_RP  (T_RP),
            .T_RAS (T_RAS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_act   (iss_act[b]),
            .do_pre   (iss_pre[b]),
            .do_col   (iss_col[b]),
            .act_row  (nxt_row),
            .st       (b_st[b]),
            .open_row (b_row[b]),
            .pre_ok   (b_preok[b])
        );
    end

    bcs_sched #(
        .DEPTH  (DEPTH),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_sched (
        .ent_vld   (q_vld),
        .ent_we    (e_we),
        .ent_bank  (e_bank),
        .ent_row   (e_row),
        .ent_col   (e_col),
        .bk_st     (b_st),
        .bk_row    (b_row),
        .bk_pre_ok (b_preok),
        .nxt_op    (nxt_op),
        .nxt_bank  (nxt_bank),
        .nxt_row   (nxt_row),
        .nxt_col   (nxt_col)
    );

    // Registered command bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= CMD_NOP;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            done_q <= 1'b0;
        end else begin
            op_q   <= nxt_op;
            bank_q <= nxt_bank;
            row_q  <= nxt_row;
            col_q  <= nxt_col;
            done_q <= q_pop;
        end
    end

    assign cmd_op   = op_q;
    assign cmd_bank = bank_q;
    assign cmd_row  = row_q;
    assign cmd_col  = col_q;
    assign done     = done_q;

    assert_done_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_op == 3'd2 || cmd_op == 3'd3));
    assert_col_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2 || cmd_op == 3'd3) |-> done);
    assert_idle_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !q_vld[0] |=> (cmd_op == 3'd0));

endmodule

// File: tb/bank_cmd_sequencer_bench.sv
module bank_cmd_sequencer_bench;
    localparam int TRCD = 3;
    localparam int TRP  = 3;
    localparam int TRAS = 6;
    localparam int LOGN = 256;

    // {write, bank, row[7:0], col, kind}; kind 1 = hit, 2 = closed, 3 = conflict
    localparam logic [20:0] VEC [8] = '{
        {1'b0, 2'd0, 8'd5, 8'd3,   2'd2},
        {1'b1, 2'd0, 8'd5, 8'd4,   2'd1},
        {1'b0, 2'd1, 8'd7, 8'd1,   2'd2},
        {1'b0, 2'd0, 8'd9, 8'd0,   2'd3},
        {1'b1, 2'd1, 8'd7, 8'd255, 2'd1},
        {1'b0, 2'd0, 8'd9, 8'd2,   2'd1},
        {1'b1, 2'd3, 8'd0, 8'd0,   2'd2},
        {1'b0, 2'd1, 8'd2, 8'd9,   2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_row;
    logic [7:0]  cmd_col;
    logic        done;

    bank_cmd_sequencer u_bank_cmd_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .cmd_col   (cmd_col),
        .done      (done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Command log
    logic [2:0]  lg_op   [LOGN];
    logic [1:0]  lg_bk   [LOGN];
    logic [11:0] lg_row  [LOGN];
    logic [7:0]  lg_col  [LOGN];
    logic        lg_done [LOGN];
    int          lg_cyc  [LOGN];
    int          lg_n = 0;
    int          stray = 0;

    always @(negedge clk) begin
        if (rst_n && cmd_op != 3'd0 && lg_n < LOGN) begin
            lg_op[lg_n]   = cmd_op;
            lg_bk[lg_n]   = cmd_bank;
            lg_row[lg_n]  = cmd_row;
            lg_col[lg_n]  = cmd_col;
            lg_done[lg_n] = done;
            lg_cyc[lg_n]  = cyc;
            lg_n = lg_n + 1;
        end
        if (rst_n && done && !(cmd_op == 3'd2 || cmd_op == 3'd3)) stray = stray + 1;
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic push(input bit we, input int bk, input int row, input int col);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_bank  = 2'(bk);
        req_row   = 12'(row);
        req_col   = 8'(col);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    int base, kind, last, a;
    logic [20:0] e;
    string rq;

    initial begin
        // Reset state (R9)
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 cmd_op in reset", int'(cmd_op), 0);
        chk("R9 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 cmd_op after reset", int'(cmd_op), 0);
        chk("R9 req_ready after reset", int'(req_ready), 1);

        // Table of single requests
        for (int v = 0; v < 8; v++) begin
            e    = VEC[v];
            kind = int'(e[1:0]);
            rq   = (kind == 1) ? "R3" : ((kind == 2) ? "R2" : "R4");
            base = lg_n;
            push(e[20], int'(e[19:18]), int'(e[17:10]), int'(e[9:2]));
            idle(20);
            chk({rq, " command count"}, lg_n - base, kind);
            last = base + kind - 1;
            chk({rq, " R10 column op"}, int'(lg_op[last]), e[20] ? 3 : 2);
            chk({rq, " R10 column bank"}, int'(lg_bk[last]), int'(e[19:18]));
            chk({rq, " R10 column addr"}, int'(lg_col[last]), int'(e[9:2]));
            chk({rq, " R7 done with column"}, int'(lg_done[last]), 1);
            if (kind >= 2) begin
                a = last - 1;
                chk("R2 activate op", int'(lg_op[a]), 1);
                chk("R10 activate row", int'(lg_row[a]), int'(e[17:10]));
                chk("R2 tRCD spacing", lg_cyc[last] - lg_cyc[a], TRCD);
            end
            if (kind == 3) begin
                chk("R4 precharge op", int'(lg_op[base]), 4);
                chk("R4 precharge bank", int'(lg_bk[base]), int'(e[19:18]));
                chk("R4 tRP spacing", lg_cyc[base + 1] - lg_cyc[base], TRP);
            end
            chk("R6 idle bus is NOP", int'(cmd_op), 0);
        end

        // Reset closes rows (R9): bank 0 had row 9 open
        do_reset();
        base = lg_n;
        push(1'b0, 0, 9, 1);
        idle(15);
        chk("R9 row closed by reset count", lg_n - base, 2);
        chk("R9 first command is activate", int'(lg_op[base]), 1);

        // Overlapped activates, in-order columns (R8, R7)
        do_reset();
        base = lg_n;
        push(1'b0, 0, 1, 1);
        push(1'b1, 1, 2, 2);
        idle(20);
        chk("R8 overlap count", lg_n - base, 4);
        chk("R8 second op activate", int'(lg_op[base + 1]), 1);
        chk("R8 second activate bank", int'(lg_bk[base + 1]), 1);
        chk("R8 second activate back to back", lg_cyc[base + 1] - lg_cyc[base], 1);
        chk("R7 first column bank", int'(lg_bk[base + 2]), 0);
        chk("R7 second column is write", int'(lg_op[base + 3]), 3);
        chk("R7 second column bank", int'(lg_bk[base + 3]), 1);

        // tRAS bound (R5)
        do_reset();
        base = lg_n;
        push(1'b0, 3, 1, 0);
        push(1'b0, 3, 2, 0);
        idle(30);
        chk("R5 count", lg_n - base, 5);
        chk("R5 precharge op", int'(lg_op[base + 2]), 4);
        chk("R5 activate to precharge", lg_cyc[base + 2] - lg_cyc[base], TRAS);

        // Precharge overlap with order kept (R7, R8)
        do_reset();
        push(1'b0, 0, 1, 0);
        push(1'b0, 1, 1, 0);
        idle(20);
        base = lg_n;
        push(1'b0, 0, 2, 5);
        push(1'b0, 1, 1, 6);
        push(1'b0, 2, 3, 7);
        idle(30);
        chk("R8 sequence count", lg_n - base, 6);
        chk("R4 first is precharge", int'(lg_op[base]), 4);
        chk("R8 early activate op", int'(lg_op[base + 1]), 1);
        chk("R8 early activate bank", int'(lg_bk[base + 1]), 2);
        chk("R7 column 1 addr", int'(lg_col[base + 3]), 5);
        chk("R7 column 2 addr", int'(lg_col[base + 4]), 6);
        chk("R7 column 3 addr", int'(lg_col[base + 5]), 7);

        // Full queue back-pressure (R1)
        do_reset();
        base = lg_n;
        for (int k = 0; k < 4; k++) push(1'b0, 2, k + 1, k);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 ready low when full", int'(req_ready), 0);
        idle(80);
        chk("R1 ready after drain", int'(req_ready), 1);
        a = 0;
        for (int k = base; k < lg_n; k++) begin
            if (lg_op[k] == 3'd2) begin
                chk("R7 drained order", int'(lg_col[k]), a);
                a++;
            end
        end
        chk("R1 all four completed", a, 4);
        chk("R7 done without column", stray, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule